// File: doc/BRIEF.md
# Queue Channel Control and Status Block

This block gives each channel of a queue-driven memory-copy engine its software-visible control and status registers, together with the state machine those registers steer. Software programs a depth and base addresses for the submission and completion rings. It rings the doorbell by moving the submission tail, and it acknowledges completions by clearing interrupt status bits. The block tracks its own fetch head and raises a start pulse toward the data mover for each pending entry. It waits for the mover's done pulse and then reports the outcome on a per-channel interrupt line.

All channels share one register port. Channel `c` owns a 256-byte window that starts at `c * 0x100`. Inside a window the state machine's 4-bit code can be read back. Enable, pause and reset follow a fixed quiesce order: set pause and clear enable, wait for the state to leave run, pulse reset, then release pause. Descriptor fetch and data movement sit outside the block. They connect only through the start and done sideband signals.

Top module: `qchan_ctrl`

## Requirements
- R1: Each channel's window holds read/write registers: ring bases at 0x00, 0x04, 0x10 and 0x14 (32 bits each), submission depth at 0x08, submission tail at 0x0C, completion depth at 0x18 and completion head at 0x1C. Each reads back the value written. Offsets with no register read as 0.
- R2: After reset: control (0x20) reads 0, the reset register (0x24) reads 0, the interrupt mask (0x44) reads 0x1FFF, and all other registers read 0. In the control register, bit 0 is enable and bit 4 is pause.
- R3: Offset 0x30 bits 3:0 report the state code: idle 0, run 1, complete 2, pause 3, halt 4, abort 5, wait 6, buffer-clear 7.
- R4: In idle, with enable set and pause clear, a tail value different from the fetch head raises `xfer_start` for exactly one cycle. The state reads run in the next cycle.
- R5: A `xfer_done` pulse in run moves the state to complete and advances the fetch head (read-only, offset 0x28). It also sets interrupt status bit 0. The next cycle returns to idle, or to pause if pause is set.
- R6: The fetch head wraps to 0 after reaching the programmed depth value, which is the entry count minus one.
- R7: Interrupt status (0x40, bits 12:0) is write-one-to-clear. `irq` is high when any status bit is set and its mask bit is 0. A mask of 0x1FFF holds `irq` low.
- R8: Pause set during run lets the current transfer finish and then holds the state at pause. No start is raised while paused. Clearing pause returns to idle and resumes pending work.
- R9: With enable clear in run and no done, the state moves to abort no more than 64 cycles after enable clears. It also sets status bit 1, and abort holds until a reset.
- R10: Writing 1 to bit 0 of offset 0x24 clears the submission tail, completion head, fetch head and interrupt status, and forces the state to idle within 2 cycles. The bit reads 1 for one cycle and then self-clears.
- R11: A write reaches only the channel whose window it addresses. Writes to windows beyond the last channel change nothing and read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address: channel index above bit 7, offset in bits 7:0 |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| xfer_done | input | NUM_CH | Per-channel transfer-finished pulse from the data mover |
| xfer_start | output | NUM_CH | Per-channel start pulse for the entry at the fetch head |
| irq | output | NUM_CH | Per-channel interrupt request |

## Verification
The assertions assume software writes a submission tail no larger than the programmed depth. They also assume the mover pulses `xfer_done` only while its channel is in run, and that a reset request is never written in two back-to-back cycles. The directed stimulus respects all three. It uses a depth of 3 and tails from 0 to 3, and it raises done only after seeing start and the run code. It issues each reset as a single write separated by idle cycles. Under those conditions the checks on start-to-run, head stepping, pause holding, the quiesce counter bound and reset clearing hold on every cycle.

// File: rtl/qchan_pkg.sv
package qchan_pkg;

  typedef enum logic [3:0] {
    ST_IDLE  = 4'd0,
    ST_RUN   = 4'd1,
    ST_CPL   = 4'd2,
    ST_PAUSE = 4'd3,
    ST_HALT  = 4'd4,
    ST_ABORT = 4'd5,
    ST_WAIT  = 4'd6,
    ST_BCLR  = 4'd7
  } qstate_e;

  localparam int STS_W      = 13;
  localparam int BIT_EN     = 0;
  localparam int BIT_PAUSE  = 4;
  localparam int BIT_SRST   = 0;
  localparam int STS_DONE   = 0;
  localparam int STS_ABORT  = 1;

  localparam logic [7:0] OFF_SQ_LO   = 8'h00;
  localparam logic [7:0] OFF_SQ_HI   = 8'h04;
  localparam logic [7:0] OFF_SQ_DEP  = 8'h08;
  localparam logic [7:0] OFF_SQ_TAIL = 8'h0C;
  localparam logic [7:0] OFF_CQ_LO   = 8'h10;
  localparam logic [7:0] OFF_CQ_HI   = 8'h14;
  localparam logic [7:0] OFF_CQ_DEP  = 8'h18;
  localparam logic [7:0] OFF_CQ_HEAD = 8'h1C;
  localparam logic [7:0] OFF_CTRL    = 8'h20;
  localparam logic [7:0] OFF_SRST    = 8'h24;
  localparam logic [7:0] OFF_FHEAD   = 8'h28;
  localparam logic [7:0] OFF_STATE   = 8'h30;
  localparam logic [7:0] OFF_ISTS    = 8'h40;
  localparam logic [7:0] OFF_IMSK    = 8'h44;

endpackage

// File: rtl/qchan_fsm.sv
module qchan_fsm
  import qchan_pkg::*;
#(
  parameter int PTR_W       = 10,
  parameter int QUIESCE_CYC = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en_i,
  input  logic             pause_i,
  input  logic             srst_i,
  input  logic [PTR_W-1:0] depth_i,
  input  logic [PTR_W-1:0] tail_i,
  input  logic             xfer_done_i,
  output logic             start_o,
  output qstate_e          state_o,
  output logic [PTR_W-1:0] head_o,
  output logic             done_evt_o,
  output logic             abort_evt_o
);

  localparam int CNT_W = $clog2(QUIESCE_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(QUIESCE_CYC - 1);

  qstate_e          state_q, state_d;
  logic [PTR_W-1:0] head_q, head_d, head_nxt;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  assign head_nxt = (head_q == depth_i) ? '0 : head_q + 1'b1;

  always_comb begin
    state_d     = state_q;
    head_d      = head_q;
    cnt_d       = '0;
    start_o     = 1'b0;
    done_evt_o  = 1'b0;
    abort_evt_o = 1'b0;
    if (srst_i) begin
      state_d = ST_IDLE;
      head_d  = '0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (pause_i) begin
            state_d = ST_PAUSE;
          end else if (en_i && (head_q != tail_i)) begin
            state_d = ST_RUN;
            start_o = 1'b1;
          end
        end
        ST_RUN: begin
          if (xfer_done_i) begin
            state_d    = ST_CPL;
            head_d     = head_nxt;
            done_evt_o = 1'b1;
          end else if (!en_i) begin
            if (cnt_q == CNT_LAST) begin
              state_d     = ST_ABORT;
              abort_evt_o = 1'b1;
            end else begin
              cnt_d = cnt_q + 1'b1;
            end
          end
        end
        ST_CPL:   state_d = pause_i ? ST_PAUSE : ST_IDLE;
        ST_PAUSE: if (!pause_i) state_d = ST_IDLE;
        ST_ABORT: state_d = ST_ABORT;
        default:  state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      head_q  <= '0;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      head_q  <= head_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state_o = state_q;
  assign head_o  = head_q;

  assert_start_to_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    start_o |=> state_q == ST_RUN);

  assert_head_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && xfer_done_i && !srst_i) |=>
      head_q == (($past(head_q) == $past(depth_i)) ? '0 : $past(head_q) + 1'b1));

  assert_pause_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_PAUSE && pause_i && !srst_i) |=> state_q == ST_PAUSE);

  assert_quiesce_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RUN && !en_i) |-> cnt_q < CNT_W'(QUIESCE_CYC));

  assert_abort_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ABORT && !srst_i) |=> state_q == ST_ABORT);

  assert_srst_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_i |=> (state_q == ST_IDLE && head_q == '0));

endmodule

// File: rtl/qchan_regs.sv
module qchan_regs
  import qchan_pkg::*;
#(
  parameter int PTR_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_i,
  input  logic [7:0]       off_i,
  input  logic [31:0]      wdata_i,
  output logic [31:0]      rdata_o,
  input  qstate_e          state_i,
  input  logic [PTR_W-1:0] fhead_i,
  input  logic             done_evt_i,
  input  logic             abort_evt_i,
  output logic             en_o,
  output logic             pause_o,
  output logic             srst_o,
  output logic [PTR_W-1:0] depth_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             irq_o
);

  localparam int PAD_W = 32 - PTR_W;

  logic [31:0]      sq_lo_q, sq_hi_q, cq_lo_q, cq_hi_q;
  logic [PTR_W-1:0] sq_dep_q, cq_dep_q;
  logic [PTR_W-1:0] tail_q, tail_d, cqh_q, cqh_d;
  logic             en_q, pause_q, srst_q, srst_d;
  logic [STS_W-1:0] sts_q, sts_d, msk_q, evt;

  logic we_sq_lo, we_sq_hi, we_cq_lo, we_cq_hi, we_sq_dep, we_cq_dep;
  logic we_tail, we_cqh, we_ctrl, we_srst, we_ists, we_imsk;

  assign we_sq_lo  = wr_i && off_i == OFF_SQ_LO;
  assign we_sq_hi  = wr_i && off_i == OFF_SQ_HI;
  assign we_cq_lo  = wr_i && off_i == OFF_CQ_LO;
  assign we_cq_hi  = wr_i && off_i == OFF_CQ_HI;
  assign we_sq_dep = wr_i && off_i == OFF_SQ_DEP;
  assign we_cq_dep = wr_i && off_i == OFF_CQ_DEP;
  assign we_tail   = wr_i && off_i == OFF_SQ_TAIL;
  assign we_cqh    = wr_i && off_i == OFF_CQ_HEAD;
  assign we_ctrl   = wr_i && off_i == OFF_CTRL;
  assign we_srst   = wr_i && off_i == OFF_SRST;
  assign we_ists   = wr_i && off_i == OFF_ISTS;
  assign we_imsk   = wr_i && off_i == OFF_IMSK;

  always_comb begin
    evt              = '0;
    evt[STS_DONE]    = done_evt_i;
    evt[STS_ABORT]   = abort_evt_i;
    srst_d           = we_srst && wdata_i[BIT_SRST];
    if (srst_q) begin
      tail_d = '0;
      cqh_d  = '0;
      sts_d  = '0;
    end else begin
      tail_d = we_tail ? wdata_i[PTR_W-1:0] : tail_q;
      cqh_d  = we_cqh  ? wdata_i[PTR_W-1:0] : cqh_q;
      sts_d  = (sts_q & ~(we_ists ? wdata_i[STS_W-1:0] : '0)) | evt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_lo_q <= '0; sq_hi_q <= '0; cq_lo_q <= '0; cq_hi_q <= '0;
      sq_dep_q <= '0; cq_dep_q <= '0;
      en_q <= 1'b0; pause_q <= 1'b0;
      msk_q <= '1;
    end else begin
      if (we_sq_lo)  sq_lo_q  <= wdata_i;
      if (we_sq_hi)  sq_hi_q  <= wdata_i;
      if (we_cq_lo)  cq_lo_q  <= wdata_i;
      if (we_cq_hi)  cq_hi_q  <= wdata_i;
      if (we_sq_dep) sq_dep_q <= wdata_i[PTR_W-1:0];
      if (we_cq_dep) cq_dep_q <= wdata_i[PTR_W-1:0];
      if (we_ctrl) begin
        en_q    <= wdata_i[BIT_EN];
        pause_q <= wdata_i[BIT_PAUSE];
      end
      if (we_imsk)   msk_q    <= wdata_i[STS_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tail_q <= '0;
      cqh_q  <= '0;
      sts_q  <= '0;
      srst_q <= 1'b0;
    end else begin
      tail_q <= tail_d;
      cqh_q  <= cqh_d;
      sts_q  <= sts_d;
      srst_q <= srst_d;
    end
  end

  always_comb begin
    unique case (off_i)
      OFF_SQ_LO:   rdata_o = sq_lo_q;
      OFF_SQ_HI:   rdata_o = sq_hi_q;
      OFF_SQ_DEP:  rdata_o = {{PAD_W{1'b0}}, sq_dep_q};
      OFF_SQ_TAIL: rdata_o = {{PAD_W{1'b0}}, tail_q};
      OFF_CQ_LO:   rdata_o = cq_lo_q;
      OFF_CQ_HI:   rdata_o = cq_hi_q;
      OFF_CQ_DEP:  rdata_o = {{PAD_W{1'b0}}, cq_dep_q};
      OFF_CQ_HEAD: rdata_o = {{PAD_W{1'b0}}, cqh_q};
      OFF_CTRL:    rdata_o = 32'(pause_q) << BIT_PAUSE | 32'(en_q) << BIT_EN;
      OFF_SRST:    rdata_o = 32'(srst_q) << BIT_SRST;
      OFF_FHEAD:   rdata_o = {{PAD_W{1'b0}}, fhead_i};
      OFF_STATE:   rdata_o = {28'd0, state_i};
      OFF_ISTS:    rdata_o = {{(32-STS_W){1'b0}}, sts_q};
      OFF_IMSK:    rdata_o = {{(32-STS_W){1'b0}}, msk_q};
      default:     rdata_o = '0;
    endcase
  end

  assign en_o    = en_q;
  assign pause_o = pause_q;
  assign srst_o  = srst_q;
  assign depth_o = sq_dep_q;
  assign tail_o  = tail_q;
  assign irq_o   = |(sts_q & ~msk_q);

  assert_w1c_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (we_ists && wdata_i[STS_DONE] && !done_evt_i) |=> !sts_q[STS_DONE]);

  assert_full_mask_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (msk_q == '1) |-> !irq_o);

  assert_srst_selfclear_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (srst_q && !we_srst) |=> !srst_q);

  assert_srst_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    srst_q |=> (sts_q == '0 && tail_q == '0 && cqh_q == '0));

endmodule

// File: rtl/qchan_ctrl.sv
module qchan_ctrl
  import qchan_pkg::*;
#(
  parameter int NUM_CH      = 3,
  parameter int PTR_W       = 10,
  parameter int QUIESCE_CYC = 64,
  parameter int ADDR_W      = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic [NUM_CH-1:0] xfer_done,
  output logic [NUM_CH-1:0] xfer_start,
  output logic [NUM_CH-1:0] irq
);

  localparam int CH_W   = ADDR_W - 8;
  localparam int N_SLOT = 1 << CH_W;

  logic [CH_W-1:0]   ch_sel;
  logic [7:0]        off;
  logic [31:0]       rd_word [N_SLOT];
  logic [NUM_CH-1:0] wr_vec;

  assign ch_sel = reg_addr[ADDR_W-1:8];
  assign off    = reg_addr[7:0];

  for (genvar c = 0; c < N_SLOT; c++) begin : g_slot
    if (c < NUM_CH) begin : g_ch
      logic             en, pause, srst, done_evt, abort_evt;
      logic [PTR_W-1:0] depth, tail, fhead;
      qstate_e          state;

      assign wr_vec[c] = reg_wr && (ch_sel == CH_W'(c));

      qchan_regs #(.PTR_W(PTR_W)) regs_i (
        .clk(clk), .rst_n(rst_n), .wr_i(wr_vec[c]), .off_i(off),
        .wdata_i(reg_wdata), .rdata_o(rd_word[c]), .state_i(state),
        .fhead_i(fhead), .done_evt_i(done_evt), .abort_evt_i(abort_evt),
        .en_o(en), .pause_o(pause), .srst_o(srst), .depth_o(depth),
        .tail_o(tail), .irq_o(irq[c])
      );

      qchan_fsm #(.PTR_W(PTR_W), .QUIESCE_CYC(QUIESCE_CYC)) fsm_i (
        .clk(clk), .rst_n(rst_n), .en_i(en), .pause_i(pause),
        .srst_i(srst), .depth_i(depth), .tail_i(tail),
        .xfer_done_i(xfer_done[c]), .start_o(xfer_start[c]),
        .state_o(state), .head_o(fhead), .done_evt_o(done_evt),
        .abort_evt_o(abort_evt)
      );
    end else begin : g_empty
      assign rd_word[c] = '0;
    end
  end

  assign reg_rdata = rd_word[ch_sel];

  assert_single_target_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_vec));

endmodule

// File: tb/qchan_ctrl_tb_top.sv
module qchan_ctrl_tb_top;

  localparam int NUM_CH = 3;
  localparam int AW     = 10;
  localparam int QC     = 64;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              reg_wr;
  logic [AW-1:0]     reg_addr;
  logic [31:0]       reg_wdata;
  logic [31:0]       reg_rdata;
  logic [NUM_CH-1:0] xfer_done;
  logic [NUM_CH-1:0] xfer_start;
  logic [NUM_CH-1:0] irq;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  qchan_ctrl #(.NUM_CH(NUM_CH), .PTR_W(10), .QUIESCE_CYC(QC), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .xfer_done(xfer_done),
    .xfer_start(xfer_start), .irq(irq)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(int ch, logic [7:0] off, logic [31:0] d);
    @(negedge clk);
    reg_wr    = 1'b1;
    reg_addr  = {ch[1:0], off};
    reg_wdata = d;
    @(negedge clk);
    reg_wr    = 1'b0;
  endtask

  task automatic rd(int ch, logic [7:0] off, output logic [31:0] d);
    reg_addr = {ch[1:0], off};
    #1;
    d = reg_rdata;
  endtask

  task automatic run_one(int ch, string tag);
    int w = 0;
    #1;
    while (!xfer_start[ch] && w < 20) begin
      @(negedge clk); #1;
      w++;
    end
    chk({tag, " start seen"}, 32'(xfer_start[ch]), 32'd1);
    @(negedge clk);
    xfer_done[ch] = 1'b1;
    @(negedge clk);
    xfer_done[ch] = 1'b0;
  endtask

  task automatic t_reset_values;
    logic [31:0] v;
    rd(0, 8'h20, v); chk("R2 ctrl reset", v, 32'h0);
    rd(0, 8'h24, v); chk("R2 reset reg", v, 32'h0);
    rd(0, 8'h44, v); chk("R2 mask reset", v, 32'h1FFF);
    rd(0, 8'h30, v); chk("R3 state idle at reset", v, 32'h0);
    chk("R2 irq low", 32'(irq), 32'h0);
    chk("R2 start low", 32'(xfer_start), 32'h0);
  endtask

  task automatic t_window;
    logic [31:0] v;
    wr(1, 8'h00, 32'hA5A5_0001);
    wr(1, 8'h04, 32'h0000_00BE);
    wr(1, 8'h10, 32'h1234_5678);
    wr(1, 8'h14, 32'hCAFE_0000);
    wr(1, 8'h18, 32'h7);
    rd(1, 8'h00, v); chk("R1 sq base lo", v, 32'hA5A5_0001);
    rd(1, 8'h04, v); chk("R1 sq base hi", v, 32'h0000_00BE);
    rd(1, 8'h10, v); chk("R1 cq base lo", v, 32'h1234_5678);
    rd(1, 8'h14, v); chk("R1 cq base hi", v, 32'hCAFE_0000);
    rd(1, 8'h18, v); chk("R1 cq depth", v, 32'h7);
    rd(1, 8'h50, v); chk("R1 unmapped offset", v, 32'h0);
    rd(0, 8'h00, v); chk("R11 ch0 untouched", v, 32'h0);
    wr(3, 8'h00, 32'hDEAD_BEEF);
    rd(3, 8'h00, v); chk("R11 missing window reads 0", v, 32'h0);
    rd(0, 8'h00, v); chk("R11 ch0 after stray write", v, 32'h0);
    rd(1, 8'h00, v); chk("R11 ch1 after stray write", v, 32'hA5A5_0001);
    rd(2, 8'h00, v); chk("R11 ch2 after stray write", v, 32'h0);
  endtask

  task automatic t_doorbell;
    logic [31:0] v;
    wr(0, 8'h08, 32'd3);
    wr(0, 8'h18, 32'd3);
    wr(0, 8'h44, 32'h0);
    wr(0, 8'h20, 32'h1);
    rd(0, 8'h08, v); chk("R1 sq depth", v, 32'd3);
    chk("R4 no start with tail equal head", 32'(xfer_start[0]), 32'd0);
    wr(0, 8'h0C, 32'd1);
    #1; chk("R4 start pulse", 32'(xfer_start[0]), 32'd1);
    @(negedge clk);
    rd(0, 8'h30, v); chk("R4 state run", v, 32'd1);
    chk("R4 start single cycle", 32'(xfer_start[0]), 32'd0);
    xfer_done[0] = 1'b1;
    @(negedge clk);
    xfer_done[0] = 1'b0;
    rd(0, 8'h30, v); chk("R5 state complete", v, 32'd2);
    rd(0, 8'h28, v); chk("R5 fetch head advanced", v, 32'd1);
    rd(0, 8'h40, v); chk("R5 done status", v, 32'd1);
    chk("R7 irq raised", 32'(irq[0]), 32'd1);
    @(negedge clk);
    rd(0, 8'h30, v); chk("R5 back to idle", v, 32'd0);
    wr(0, 8'h40, 32'h1);
    rd(0, 8'h40, v); chk("R7 w1c cleared", v, 32'd0);
    chk("R7 irq dropped", 32'(irq[0]), 32'd0);
  endtask

  task automatic t_wrap;
    logic [31:0] v;
    wr(0, 8'h0C, 32'd0);
    for (int k = 0; k < 3; k++) run_one(0, "R6 wrap xfer");
    @(negedge clk);
    rd(0, 8'h28, v); chk("R6 head wrapped to 0", v, 32'd0);
    rd(0, 8'h30, v); chk("R6 idle after wrap", v, 32'd0);
    wr(0, 8'h44, 32'h1FFF);
    chk("R7 full mask holds irq low", 32'(irq[0]), 32'd0);
    wr(0, 8'h44, 32'h0);
    chk("R7 unmask raises irq", 32'(irq[0]), 32'd1);
    wr(0, 8'h40, 32'h1FFF);
    chk("R7 irq after clear", 32'(irq[0]), 32'd0);
  endtask

  task automatic t_pause;
    logic [31:0] v;
    wr(0, 8'h0C, 32'd1);
    #1; chk("R8 start before pause", 32'(xfer_start[0]), 32'd1);
    @(negedge clk);
    wr(0, 8'h20, 32'h11);
    wr(0, 8'h0C, 32'd2);
    rd(0, 8'h30, v); chk("R8 still run while paused", v, 32'd1);
    xfer_done[0] = 1'b1;
    @(negedge clk);
    xfer_done[0] = 1'b0;
    rd(0, 8'h30, v); chk("R8 transfer finished", v, 32'd2);
    @(negedge clk);
    rd(0, 8'h30, v); chk("R8 state pause", v, 32'd3);
    @(negedge clk); #1;
    rd(0, 8'h30, v); chk("R8 pause holds", v, 32'd3);
    chk("R8 no start while paused", 32'(xfer_start[0]), 32'd0);
    wr(0, 8'h20, 32'h01);
    run_one(0, "R8 resume");
    @(negedge clk);
    rd(0, 8'h28, v); chk("R8 head after resume", v, 32'd2);
    wr(0, 8'h40, 32'h1FFF);
  endtask

  task automatic t_abort;
    logic [31:0] v;
    int n = 0;
    wr(0, 8'h0C, 32'd3);
    #1; chk("R9 start", 32'(xfer_start[0]), 32'd1);
    @(negedge clk);
    wr(0, 8'h20, 32'h10);
    rd(0, 8'h30, v);
    while (v == 32'd1 && n < 100) begin
      @(negedge clk);
      n++;
      rd(0, 8'h30, v);
    end
    chk("R9 abort code", v, 32'd5);
    chk("R9 left run within bound", 32'(n <= QC), 32'd1);
    rd(0, 8'h40, v); chk("R9 abort status bit", v, 32'h2);
    xfer_done[0] = 1'b1;
    @(negedge clk);
    xfer_done[0] = 1'b0;
    rd(0, 8'h30, v); chk("R9 abort sticky", v, 32'd5);
  endtask

  task automatic t_chan_reset;
    logic [31:0] v;
    wr(0, 8'h1C, 32'd2);
    wr(0, 8'h24, 32'h1);
    rd(0, 8'h24, v); chk("R10 reset bit visible", v, 32'h1);
    @(negedge clk);
    rd(0, 8'h24, v); chk("R10 reset bit self-clear", v, 32'h0);
    rd(0, 8'h30, v); chk("R10 idle within 2 cycles", v, 32'd0);
    rd(0, 8'h0C, v); chk("R10 tail cleared", v, 32'd0);
    rd(0, 8'h1C, v); chk("R10 cq head cleared", v, 32'd0);
    rd(0, 8'h28, v); chk("R10 fetch head cleared", v, 32'd0);
    rd(0, 8'h40, v); chk("R10 status cleared", v, 32'd0);
    chk("R10 irq low", 32'(irq[0]), 32'd0);
    wr(0, 8'h20, 32'h01);
    @(negedge clk); #1;
    rd(0, 8'h30, v); chk("R10 idle after pause release", v, 32'd0);
    chk("R10 no start after reset", 32'(xfer_start[0]), 32'd0);
    rd(1, 8'h30, v); chk("R11 ch1 state untouched", v, 32'd0);
    chk("R11 other irqs low", 32'(irq[2:1]), 32'd0);
  endtask

  task automatic summary;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    rst_n     = 1'b0;
    reg_wr    = 1'b0;
    reg_addr  = '0;
    reg_wdata = '0;
    xfer_done = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_values();
    t_window();
    t_doorbell();
    t_wrap();
    t_pause();
    t_abort();
    t_chan_reset();
    repeat (2) @(negedge clk);
    summary();
    $finish;
  end

endmodule